// File: doc/BRIEF.md
# DDR Native-Port Traffic Generator

This block is a user-side master for the native command and write-data ports of a DDR memory controller. After reset it runs a fixed test program. It writes a block of commands back to back. It then reads the same addresses back to back. It repeats the write and read blocks once with a second data pattern, and then rests. Read data that returns from the controller is compared against a regenerated copy of the pattern. Any mismatch sets an error flag that stays set. A one-cycle pulse marks the end of the program.

The command channel and the write-data channel use separate enable/ready handshakes. Each enable is raised without waiting for ready, and its payload is held until the transfer completes. Write data is pushed ahead of its command. The command for a write is released only after both of its data beats have been accepted, so the controller never waits on data for a command it already holds. How far the data may run ahead is bounded by a parameter, which keeps the controller's write buffer from being flooded.

Top module: `tg_top`

## Requirements
- R1: While reset is asserted, `cmd_en`, `wd_en`, `done` and `err` are all low.
- R2: Once `cmd_en` is high in a cycle where `cmd_rdy` is low, the next cycle still has `cmd_en` high with unchanged `cmd_op` and `cmd_addr`. A command transfers only on a clock edge where both are high.
- R3: Once `wd_en` is high in a cycle where `wd_rdy` is low, the next cycle still has `wd_en` high with unchanged `wd_data` and `wd_last`. A beat transfers only on an edge where both are high.
- R4: The program issues these blocks in order: write, read, write, read. Each block has CMDS_PER_BLOCK commands. Command k of a block uses address BASE_ADDR + 8*k. The opcode is 3'b000 for a write and 3'b001 for a read.
- R5: A write command k is offered only after both data beats of command k have been accepted on an earlier edge. The beats accepted within a write block never exceed 2*(write commands accepted + AHEAD_MAX).
- R6: Each write command carries exactly two data beats. `wd_last` is low on the first beat (even beat index within the block) and high on the second beat (odd index).
- R7: Data beat b of a block (b counted from 0 within the block) carries, in every 32-bit lane, the word {b[15:0], ~b[15:0]}. In the second write block this word is XORed with 32'hA5A5A5A5.
- R8: During a read block, each `rd_valid` beat is compared in order against the R7 pattern of the preceding write block. A mismatch sets `err`, and `err` stays high until reset.
- R9: `rd_valid` has no effect outside a read block: it neither counts as a returned beat nor touches `err`.
- R10: When the last read block completes, `done` is high for exactly one cycle. After that, neither enable is raised again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_en | output | 1 | Command offered |
| cmd_op | output | 3 | Command opcode: 000 write, 001 read |
| cmd_addr | output | ADDR_W | Command address |
| cmd_rdy | input | 1 | Controller accepts a command this cycle |
| wd_en | output | 1 | Write-data beat offered |
| wd_data | output | DATA_W | Write-data beat |
| wd_last | output | 1 | Second (final) beat of a command |
| wd_rdy | input | 1 | Controller accepts a data beat this cycle |
| rd_valid | input | 1 | Returned read beat valid |
| rd_data | input | DATA_W | Returned read beat |
| done | output | 1 | One-cycle pulse at program end |
| err | output | 1 | Sticky read-compare mismatch |

## Verification
The bench goes after payload stability under stalls. A design that advanced its counters on enable alone would change the address or data while ready is low, or skip items. With the command ready held low, the write-data lead must stop at exactly the window size. A design without the limit keeps streaming beats, and a design that gated commands badly would issue a write before its data. Spurious read-valid strobes during the first write block must leave the error flag clear. A design that counted them would shift its compare index and flag the good data returned later. A single corrupted read beat must set the error flag and keep it set through the end of the program. The bench also checks that the end pulse lasts one cycle and that no traffic follows it.

// File: rtl/tg_pkg.sv
package tg_pkg;

  typedef enum logic [2:0] {
    PH_START = 3'd0,
    PH_WR0   = 3'd1,
    PH_RD0   = 3'd2,
    PH_WR1   = 3'd3,
    PH_RD1   = 3'd4,
    PH_REST  = 3'd5
  } phase_t;

  localparam logic [2:0]  OP_WRITE   = 3'b000;
  localparam logic [2:0]  OP_READ    = 3'b001;
  localparam logic [31:0] PASS1_MASK = 32'hA5A5_A5A5;

  // One 32-bit lane of the data pattern for a beat index within a block.
  function automatic logic [31:0] pattern_word(input logic pass, input logic [15:0] beat);
    return {beat, ~beat} ^ (pass ? PASS1_MASK : 32'h0);
  endfunction

endpackage

// File: rtl/tg_seq.sv
module tg_seq
  import tg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_done,
  input  logic rd_done,
  output logic is_wr,
  output logic is_rd,
  output logic is_rest,
  output logic pass,
  output logic clr,
  output logic done
);

  phase_t phase_q, phase_d;
  logic   done_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_START: phase_d = PH_WR0;
      PH_WR0:   if (wr_done) phase_d = PH_RD0;
      PH_RD0:   if (rd_done) phase_d = PH_WR1;
      PH_WR1:   if (wr_done) phase_d = PH_RD1;
      PH_RD1:   if (rd_done) phase_d = PH_REST;
      PH_REST:  phase_d = PH_REST;
      default:  phase_d = PH_START;
    endcase
  end

  assign done_d = (phase_q != PH_REST) && (phase_d == PH_REST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_START;
      done    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done    <= done_d;
    end
  end

  assign clr     = (phase_d != phase_q);
  assign is_wr   = (phase_q == PH_WR0) || (phase_q == PH_WR1);
  assign is_rd   = (phase_q == PH_RD0) || (phase_q == PH_RD1);
  assign is_rest = (phase_q == PH_REST);
  assign pass    = (phase_q == PH_WR1) || (phase_q == PH_RD1);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_rest_final_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_rest |=> is_rest);

endmodule

// File: rtl/tg_cmd_gen.sv
module tg_cmd_gen
  import tg_pkg::*;
#(
  parameter int             ADDR_W = 28,
  parameter int             NCMD   = 8,
  parameter int             CNT_W  = 5,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              is_wr,
  input  logic              is_rd,
  input  logic [CNT_W-1:0]  wd_beats,
  input  logic              cmd_rdy,
  output logic              cmd_en,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [CNT_W-1:0]  cmd_cnt
);

  localparam logic [CNT_W-1:0] NCMD_C = CNT_W'(NCMD);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   need_beats;
  logic             left, accept;

  assign left       = (cnt_q < NCMD_C);
  assign need_beats = ({1'b0, cnt_q} + (CNT_W+1)'(1)) << 1;

  always_comb begin
    cmd_en = 1'b0;
    if (is_wr) cmd_en = left && ({1'b0, wd_beats} >= need_beats);
    if (is_rd) cmd_en = left;
  end

  assign accept   = cmd_en && cmd_rdy;
  assign cmd_op   = is_wr ? OP_WRITE : OP_READ;
  assign cmd_addr = BASE + (ADDR_W'(cnt_q) << 3);
  assign cmd_cnt  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (accept) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && !cmd_rdy) |=> (cmd_en && $stable(cmd_addr) && $stable(cmd_op)));

endmodule

// File: rtl/tg_wdata_gen.sv
module tg_wdata_gen
  import tg_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int NCMD      = 8,
  parameter int AHEAD_MAX = 3,
  parameter int CNT_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              is_wr,
  input  logic              pass,
  input  logic [CNT_W-1:0]  cmd_cnt,
  input  logic              wd_rdy,
  output logic              wd_en,
  output logic [DATA_W-1:0] wd_data,
  output logic              wd_last,
  output logic [CNT_W-1:0]  beats
);

  localparam int               LANES   = DATA_W / 32;
  localparam logic [CNT_W-1:0] BEATS_C = CNT_W'(2 * NCMD);
  localparam logic [CNT_W-1:0] AHEAD_C = CNT_W'(AHEAD_MAX);

  logic [CNT_W-1:0] beats_q, beats_d, lead;
  logic [31:0]      word;
  logic             accept;

  // Command data sets fully delivered but whose command is not yet accepted.
  assign lead   = (beats_q >> 1) - cmd_cnt;
  assign wd_en  = is_wr && (beats_q < BEATS_C) && (lead < AHEAD_C);
  assign accept = wd_en && wd_rdy;
  assign word   = pattern_word(pass, 16'(beats_q));
  assign wd_last = beats_q[0];
  assign beats  = beats_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wd_data[32*g +: 32] = word;
  end

  always_comb begin
    beats_d = beats_q;
    if (clr)         beats_d = '0;
    else if (accept) beats_d = beats_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beats_q <= '0;
    else        beats_q <= beats_d;
  end

  assert_wd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_en && !wd_rdy) |=> (wd_en && $stable(wd_data) && $stable(wd_last)));

endmodule

// File: rtl/tg_rd_check.sv
module tg_rd_check
  import tg_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NCMD   = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              is_rd,
  input  logic              pass,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic              err
);

  localparam int               LANES   = DATA_W / 32;
  localparam logic [CNT_W-1:0] BEATS_C = CNT_W'(2 * NCMD);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] expect_data;
  logic [31:0]       word;
  logic              take, err_d;

  assign take = rd_valid && is_rd && (cnt_q < BEATS_C);
  assign word = pattern_word(pass, 16'(cnt_q));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign expect_data[32*g +: 32] = word;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (take) cnt_d = cnt_q + 1'b1;
  end

  assign err_d = err || (take && (rd_data != expect_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err   <= err_d;
    end
  end

  assign rd_cnt = cnt_q;

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_ignore_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_rd && !clr) |=> $stable(rd_cnt));

endmodule

// File: rtl/tg_top.sv
module tg_top
  import tg_pkg::*;
#(
  parameter int                ADDR_W         = 28,
  parameter int                DATA_W         = 64,
  parameter int                CMDS_PER_BLOCK = 8,
  parameter int                AHEAD_MAX      = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR      = 28'h000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cmd_en,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_rdy,
  output logic              wd_en,
  output logic [DATA_W-1:0] wd_data,
  output logic              wd_last,
  input  logic              wd_rdy,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              err
);

  localparam int               CNT_W   = $clog2(2 * CMDS_PER_BLOCK + 1);
  localparam logic [CNT_W-1:0] NCMD_C  = CNT_W'(CMDS_PER_BLOCK);
  localparam logic [CNT_W-1:0] BEATS_C = CNT_W'(2 * CMDS_PER_BLOCK);

  logic [1:0]       rst_sync;
  logic             rst_i_n;
  logic             is_wr, is_rd, is_rest, pass, clr;
  logic             wr_done, rd_done;
  logic [CNT_W-1:0] cmd_cnt, wd_beats, rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  assign wr_done = (cmd_cnt == NCMD_C) && (wd_beats == BEATS_C);
  assign rd_done = (cmd_cnt == NCMD_C) && (rd_cnt == BEATS_C);

  tg_seq u_seq (
    .clk(clk), .rst_n(rst_i_n), .wr_done(wr_done), .rd_done(rd_done),
    .is_wr(is_wr), .is_rd(is_rd), .is_rest(is_rest), .pass(pass),
    .clr(clr), .done(done)
  );

  tg_cmd_gen #(.ADDR_W(ADDR_W), .NCMD(CMDS_PER_BLOCK), .CNT_W(CNT_W), .BASE(BASE_ADDR)) u_cmd (
    .clk(clk), .rst_n(rst_i_n), .clr(clr), .is_wr(is_wr), .is_rd(is_rd),
    .wd_beats(wd_beats), .cmd_rdy(cmd_rdy), .cmd_en(cmd_en), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_cnt(cmd_cnt)
  );

  tg_wdata_gen #(.DATA_W(DATA_W), .NCMD(CMDS_PER_BLOCK), .AHEAD_MAX(AHEAD_MAX), .CNT_W(CNT_W)) u_wd (
    .clk(clk), .rst_n(rst_i_n), .clr(clr), .is_wr(is_wr), .pass(pass),
    .cmd_cnt(cmd_cnt), .wd_rdy(wd_rdy), .wd_en(wd_en), .wd_data(wd_data),
    .wd_last(wd_last), .beats(wd_beats)
  );

  tg_rd_check #(.DATA_W(DATA_W), .NCMD(CMDS_PER_BLOCK), .CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst_n(rst_i_n), .clr(clr), .is_rd(is_rd), .pass(pass),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_cnt(rd_cnt), .err(err)
  );

  // Port-level transfer counters kept only for the checks below.
  logic [CNT_W:0] chk_wbeats, chk_wcmds;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      chk_wbeats <= '0;
      chk_wcmds  <= '0;
    end else if (clr) begin
      chk_wbeats <= '0;
      chk_wcmds  <= '0;
    end else begin
      if (wd_en && wd_rdy) chk_wbeats <= chk_wbeats + 1'b1;
      if (cmd_en && cmd_rdy && (cmd_op == OP_WRITE)) chk_wcmds <= chk_wcmds + 1'b1;
    end
  end

  assert_data_first_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_en && cmd_rdy && (cmd_op == OP_WRITE)) |-> (int'(chk_wbeats) >= 2 * (int'(chk_wcmds) + 1)));

  assert_lead_window_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    int'(chk_wbeats) <= 2 * (int'(chk_wcmds) + AHEAD_MAX));

  assert_rest_quiet_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    is_rest |-> (!cmd_en && !wd_en));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_i_n |-> (!cmd_en && !wd_en && !done && !err));

endmodule

// File: tb/tg_top_tb_top.sv
module tg_top_tb_top;

  localparam int             N    = 8;
  localparam int             AH   = 3;
  localparam int             AW   = 28;
  localparam int             DW   = 64;
  localparam logic [AW-1:0]  BASE = 28'h000_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_rdy = 1'b0, wd_rdy = 1'b0, rd_valid = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic cmd_en, wd_en, wd_last, done, err;
  logic [2:0] cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] wd_data;

  always #10 clk = ~clk;

  tg_top #(.ADDR_W(AW), .DATA_W(DW), .CMDS_PER_BLOCK(N), .AHEAD_MAX(AH), .BASE_ADDR(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_rdy(cmd_rdy), .wd_en(wd_en), .wd_data(wd_data), .wd_last(wd_last),
    .wd_rdy(wd_rdy), .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err)
  );

  int checks = 0, fails = 0;
  bit active = 0, hold_cmd = 0, err_seen = 0, ret_half = 0;
  bit p_cmd = 0, p_wd = 0, p_last = 0;
  logic [AW-1:0] p_addr;
  logic [2:0] p_op;
  logic [DW-1:0] p_data;
  int cmd_i = 0, beat_i = 0, done_cnt = 0, ret_cnt = 0, corrupt_at = 0, spur_n = 0, ret_idx = 0;
  logic [DW-1:0] mem [0:2*N-1];
  logic [DW-1:0] wq [$];
  int rq [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_beat(input int p, input int b);
    logic [15:0] bb;
    logic [31:0] w;
    bb = b[15:0];
    w = {bb, ~bb};
    if (p != 0) w = w ^ 32'hA5A5_A5A5;
    return {w, w};
  endfunction

  task automatic step();
    int blk, k, p, b, bb, blk_cmds;
    if (done) done_cnt++;
    if (err_seen && !err) chk(0, "R8", "err dropped", 64'(err), 64'd1);
    if (err) err_seen = 1;
    if (p_cmd) chk(cmd_en && cmd_addr == p_addr && cmd_op == p_op, "R2", "command held",
                   {cmd_en, cmd_op, cmd_addr}, {1'b1, p_op, p_addr});
    if (p_wd) chk(wd_en && wd_data == p_data && wd_last == p_last, "R3", "beat held",
                  64'(wd_data), 64'(p_data));
    // drive controller side for the next edge
    cmd_rdy = hold_cmd ? 1'b0 : (($urandom % 100) < 65);
    wd_rdy  = hold_cmd ? 1'b1 : (($urandom % 100) < 70);
    rd_valid = 1'b0;
    rd_data = '0;
    if (spur_n > 0) begin
      spur_n--;
      rd_valid = 1'b1;
      rd_data = 64'hDEAD_BEEF_0BAD_F00D;
    end else if (ret_half) begin
      rd_valid = 1'b1;
      rd_data = mem[ret_idx*2+1];
      ret_half = 0;
      ret_cnt++;
    end else if (rq.size() > 0 && ($urandom % 100) < 60) begin
      ret_idx = rq.pop_front();
      rd_valid = 1'b1;
      rd_data = mem[ret_idx*2];
      ret_half = 1;
      ret_cnt++;
    end
    if (rd_valid && spur_n == 0 && ret_cnt == corrupt_at && corrupt_at != 0) begin
      rd_data[0] = ~rd_data[0];
      corrupt_at = 0;
    end
    #1;
    if (cmd_en && cmd_rdy) begin
      if (cmd_i >= 4*N) chk(0, "R10", "extra command", 64'(cmd_i), 64'(4*N));
      else begin
        blk = cmd_i / N;
        k = cmd_i % N;
        chk(cmd_op == ((blk % 2 == 0) ? 3'b000 : 3'b001) && cmd_addr == BASE + AW'(8*k),
            "R4", "command op/addr", {cmd_op, cmd_addr},
            {((blk % 2 == 0) ? 3'b000 : 3'b001), BASE + AW'(8*k)});
        if (blk % 2 == 0) begin
          bb = beat_i - (blk/2)*2*N;
          chk(bb >= 2*(k+1), "R5", "write data before command", 64'(bb), 64'(2*(k+1)));
          if (wq.size() >= 2) begin
            mem[2*k] = wq.pop_front();
            mem[2*k+1] = wq.pop_front();
          end
        end else rq.push_back(k);
        cmd_i++;
      end
    end
    if (wd_en && wd_rdy) begin
      if (beat_i >= 4*N) chk(0, "R10", "extra beat", 64'(beat_i), 64'(4*N));
      else begin
        p = beat_i / (2*N);
        b = beat_i % (2*N);
        chk(wd_data == exp_beat(p, b), "R7", "beat pattern", 64'(wd_data), 64'(exp_beat(p, b)));
        chk(wd_last == b[0], "R6", "last flag", 64'(wd_last), 64'(b[0]));
        wq.push_back(wd_data);
        beat_i++;
        blk_cmds = cmd_i - p*2*N;
        chk(b + 1 <= 2*(blk_cmds + AH), "R5", "lead window", 64'(b+1), 64'(2*(blk_cmds+AH)));
      end
    end
    p_cmd = cmd_en && !cmd_rdy;
    p_addr = cmd_addr;
    p_op = cmd_op;
    p_wd = wd_en && !wd_rdy;
    p_data = wd_data;
    p_last = wd_last;
  endtask

  initial forever begin
    @(negedge clk);
    if (!active) begin
      cmd_rdy = 1'b0;
      wd_rdy = 1'b0;
      rd_valid = 1'b0;
    end else step();
  end

  task automatic run(input int corrupt, input int spur, input bit holdc, input bit exp_err);
    int t;
    active = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #3;
    chk(!cmd_en && !wd_en && !done && !err, "R1", "outputs in reset",
        {cmd_en, wd_en, done, err}, 64'd0);
    cmd_i = 0; beat_i = 0; done_cnt = 0; ret_cnt = 0; err_seen = 0; ret_half = 0;
    p_cmd = 0; p_wd = 0;
    wq.delete();
    rq.delete();
    corrupt_at = corrupt;
    spur_n = spur;
    hold_cmd = holdc;
    rst_n = 1'b1;
    active = 1;
    if (holdc) begin
      repeat (60) @(negedge clk);
      #3;
      chk(beat_i == 2*AH, "R5", "beats with command stalled", 64'(beat_i), 64'(2*AH));
      chk(cmd_i == 0, "R2", "no command while not ready", 64'(cmd_i), 64'd0);
      hold_cmd = 0;
    end
    t = 0;
    while (done_cnt == 0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      #3;
      if (cmd_en || wd_en) chk(0, "R10", "traffic after done", {cmd_en, wd_en}, 64'd0);
    end
    chk(done_cnt == 1, "R10", "done pulses", 64'(done_cnt), 64'd1);
    chk(cmd_i == 4*N, "R4", "command count", 64'(cmd_i), 64'(4*N));
    chk(beat_i == 4*N, "R6", "beat count", 64'(beat_i), 64'(4*N));
    if (exp_err) chk(err == 1'b1, "R8", "mismatch flagged", 64'(err), 64'd1);
    else         chk(err == 1'b0, "R9", "no false error", 64'(err), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    run(0, 5, 1'b0, 1'b0);  // spurious read strobes during first write block
    run(3, 0, 1'b0, 1'b1);  // third returned beat corrupted
    run(0, 0, 1'b1, 1'b0);  // command ready held low: lead window
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule